// File: doc/BRIEF.md
# Flash Protection Register and Checker

This block guards a flash array against unwanted program and erase operations. An 8-bit protection configuration defines one window that ends at the top of the array and a second window that starts at a fixed base address inside it. A mode bit decides how the windows are read. With the mode bit set, each enabled window is protected. With it clear, each enabled window is open and every other address is protected. The configuration is loaded from a stored byte during the reset sequence. If that load reports an uncorrectable double-bit fault, the block falls back to protecting the whole array.

Software can rewrite the configuration, but a write is taken only if it leaves every protected address protected. A size field is also frozen while its window is enabled. Each program, sector-erase or block-erase request gets a grant or deny answer one clock later. A denied request sets a sticky violation flag, which stays set until software writes 1 to clear it.

Top module: `nvm_prot_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads `prot_cfg` = 0x7F and clears `rsp_valid`, `rsp_grant` and `prot_viol`.
- R2: A cycle with `load_valid` high copies `load_byte` into `prot_cfg` on the next edge. If `load_dbl_fault` is also high, `prot_cfg` becomes 0x7F instead: mode clear and every other bit set.
- R3: The `prot_cfg` bits are: bit 7 mode, bit 6 reserved, bit 5 high-window disable, bits 4:3 high size, bit 2 low-window disable, bits 1:0 low size. The high window covers the top 2, 4, 8 or 16 KB of the space ending at 0x3FFFF. The low window covers 1, 2, 4 or 8 KB starting at 0x38000. A disable bit of 1 removes its window. When mode is 1, the enabled windows are protected. When mode is 0, every address outside the enabled windows is protected.
- R4: A request with `cmd_type` 00 (program) or 01 (sector erase) produces `rsp_valid` one cycle later. `rsp_grant` is 1 only if `cmd_addr` is unprotected under the configuration held when the request was made.
- R5: A request with `cmd_type` 1x (block erase) ignores `cmd_addr`. It is denied if any address in the array (0x20000 to 0x3FFFF) is protected.
- R6: A software write (`reg_wr`) is accepted only if every address protected before the write is still protected under the written value. Otherwise `prot_cfg` keeps its old value.
- R7: A software write that changes a size field whose window is currently enabled (disable bit 0) is rejected as a whole.
- R8: Software writes never change reserved bit 6. It changes only through the reset load.
- R9: `prot_viol` is set by a denied request and is cleared by `stat_clr`. If a denial and a clear fall in the same cycle, the flag ends up set.
- R10: When `load_valid` and `reg_wr` are high in the same cycle, the load is applied and the software write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Reset-sequence load of the stored protection byte |
| load_dbl_fault | input | 1 | Double-bit fault reported for the loaded byte |
| load_byte | input | 8 | Stored protection byte |
| reg_wr | input | 1 | Software write strobe for the configuration |
| reg_wdata | input | 8 | Software write data |
| cmd_valid | input | 1 | Program or erase request |
| cmd_type | input | 2 | 00 program, 01 sector erase, 1x block erase |
| cmd_addr | input | 18 | Target address of the request |
| stat_clr | input | 1 | Write-1-to-clear for the violation flag |
| prot_cfg | output | 8 | Current protection configuration |
| rsp_valid | output | 1 | Answer to the request from the previous cycle |
| rsp_grant | output | 1 | 1 = operation may proceed, 0 = denied |
| prot_viol | output | 1 | Sticky protection-violation flag |

## Verification
The assertions check these on every cycle: the one-cycle response latency, that a denial always shows on the violation flag, that the flag holds until cleared, that a frozen size field keeps its value, that the reserved bit is kept, and what each kind of load leaves behind. Some properties need the address map, so only the bench can show them: which addresses each configuration protects, whether a block erase is refused, and whether a write would shrink the protected set. For these the bench compares every cycle against a behavioural model. The model scans the whole array in sector steps.

// File: rtl/nvm_prot_pkg.sv
// Shared types for the flash protection unit.
// Assumes the configuration byte layout given in the brief; the reserved
// bit is kept outside the struct so that every struct field is live logic.
package nvm_prot_pkg;

    // Implemented configuration fields, MSB first (bit 6 removed)
    typedef struct packed {
        logic       mode;     // 1: windows protected, 0: windows open
        logic       hi_dis;   // high window disable
        logic [1:0] hi_size;  // high window size code
        logic       lo_dis;   // low window disable
        logic [1:0] lo_size;  // low window size code
    } prot_cfg_t;

    // Request kinds; bit 1 set means block erase
    typedef enum logic [1:0] {
        CMD_PROGRAM  = 2'b00,
        CMD_SECT_ERS = 2'b01,
        CMD_BLK_ERS  = 2'b10,
        CMD_BLK_ERS2 = 2'b11
    } cmd_kind_t;

    // Configuration forced after an uncorrectable fault on the load
    localparam prot_cfg_t FAULT_CFG = '{mode: 1'b0, hi_dis: 1'b1, hi_size: 2'b11,
                                        lo_dis: 1'b1, lo_size: 2'b11};

endpackage

// File: rtl/nvm_prot_window.sv
// Decides whether one address is protected under a configuration.
// Assumes the high window ends at TOP_ADDR, the low window starts at
// LOW_BASE, and the two windows cannot overlap at any size code.
module nvm_prot_window
    import nvm_prot_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int unsigned TOP_ADDR = 'h3FFFF,
    parameter int unsigned LOW_BASE = 'h38000,
    parameter int          HI_MIN_W = 11,
    parameter int          LO_MIN_W = 10
) (
    input  prot_cfg_t         cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] hi_len, lo_len, hi_start, lo_end, a_ext;
    logic          in_hi, in_lo;

    // Window bounds from the size codes, then membership and mode
    always_comb begin
        hi_len   = (EW'(1) << HI_MIN_W) << cfg.hi_size;
        lo_len   = (EW'(1) << LO_MIN_W) << cfg.lo_size;
        hi_start = EW'(TOP_ADDR) + EW'(1) - hi_len;
        lo_end   = EW'(LOW_BASE) + lo_len;
        a_ext    = {1'b0, addr};
        in_hi    = !cfg.hi_dis && (a_ext >= hi_start);
        in_lo    = !cfg.lo_dis && (a_ext >= EW'(LOW_BASE)) && (a_ext < lo_end);
        prot     = cfg.mode ? (in_hi | in_lo) : !(in_hi | in_lo);
    end

endmodule

// File: rtl/nvm_prot_grow_guard.sv
// Compares the protected set of the current and a proposed configuration.
// Windows only vary in the region LOW_BASE..TOP_ADDR, in steps no finer
// than 2**GRAN_W bytes, so one sample per granule plus one sample outside
// that region (OUT_ADDR) covers every address of the array.
module nvm_prot_grow_guard
    import nvm_prot_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int unsigned TOP_ADDR = 'h3FFFF,
    parameter int unsigned LOW_BASE = 'h38000,
    parameter int unsigned OUT_ADDR = 'h20000,
    parameter int          GRAN_W   = 10,
    parameter int          HI_MIN_W = 11,
    parameter int          LO_MIN_W = 10
) (
    input  prot_cfg_t cur_cfg,
    input  prot_cfg_t nxt_cfg,
    output logic      grows_only,
    output logic      cur_any_prot
);
    localparam int NGRAN = int'((TOP_ADDR + 1 - LOW_BASE) >> GRAN_W);
    localparam int NPT   = NGRAN + 1;

    logic [NPT-1:0] cur_map, nxt_map;

    // One pair of window evaluators per sample point
    for (genvar g = 0; g < NPT; g++) begin : g_pt
        localparam int unsigned PT_ADDR =
            (g == NGRAN) ? OUT_ADDR : LOW_BASE + (int'(g) << GRAN_W);

        nvm_prot_window #(
            .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .LOW_BASE(LOW_BASE),
            .HI_MIN_W(HI_MIN_W), .LO_MIN_W(LO_MIN_W)
        ) i_cur (
            .cfg (cur_cfg),
            .addr(ADDR_W'(PT_ADDR)),
            .prot(cur_map[g])
        );

        nvm_prot_window #(
            .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .LOW_BASE(LOW_BASE),
            .HI_MIN_W(HI_MIN_W), .LO_MIN_W(LO_MIN_W)
        ) i_nxt (
            .cfg (nxt_cfg),
            .addr(ADDR_W'(PT_ADDR)),
            .prot(nxt_map[g])
        );
    end

    // Containment: no point protected now may become unprotected
    always_comb begin
        grows_only   = &(~cur_map | nxt_map);
        cur_any_prot = |cur_map;
    end

endmodule

// File: rtl/nvm_prot_cmd_check.sv
// Decides whether a program or erase request must be refused.
// Assumes cmd_addr lies inside the array and that a sector never straddles
// a window edge, so checking the given address stands for the whole sector.
module nvm_prot_cmd_check
    import nvm_prot_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int unsigned TOP_ADDR = 'h3FFFF,
    parameter int unsigned LOW_BASE = 'h38000,
    parameter int          HI_MIN_W = 11,
    parameter int          LO_MIN_W = 10
) (
    input  prot_cfg_t         cfg,
    input  cmd_kind_t         kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              any_prot,
    output logic              deny
);
    logic addr_prot;

    nvm_prot_window #(
        .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .LOW_BASE(LOW_BASE),
        .HI_MIN_W(HI_MIN_W), .LO_MIN_W(LO_MIN_W)
    ) i_win (
        .cfg (cfg),
        .addr(addr),
        .prot(addr_prot)
    );

    // Block erase needs the whole array open; the others need one address
    always_comb begin
        unique case (kind)
            CMD_BLK_ERS, CMD_BLK_ERS2: deny = any_prot;
            default:                   deny = addr_prot;
        endcase
    end

endmodule

// File: rtl/nvm_prot_unit.sv
// Flash protection register and request checker (top).
// Holds the protection configuration, loads it during the reset sequence,
// lets software only enlarge the protected set, answers each request one
// cycle later and keeps a sticky violation flag.
// Assumes ARR_BASE lies below LOW_BASE and outside both windows.
module nvm_prot_unit
    import nvm_prot_pkg::*;
#(
    parameter int          ADDR_W   = 18,
    parameter int unsigned ARR_BASE = 'h20000,
    parameter int unsigned LOW_BASE = 'h38000,
    parameter int unsigned TOP_ADDR = 'h3FFFF,
    parameter int          GRAN_W   = 10,
    parameter int          HI_MIN_W = 11,
    parameter int          LO_MIN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic              load_dbl_fault,
    input  logic [7:0]        load_byte,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              stat_clr,
    output logic [7:0]        prot_cfg,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              prot_viol
);
    prot_cfg_t cfg_q, wr_cfg, ld_cfg;
    logic      rsv_q;
    logic      grows_only, any_prot, size_ok, wr_accept, cmd_deny;
    logic      wdata_rsv_unused;

    // Split incoming bytes into the implemented fields
    always_comb begin
        wr_cfg           = prot_cfg_t'({reg_wdata[7], reg_wdata[5:0]});
        ld_cfg           = prot_cfg_t'({load_byte[7], load_byte[5:0]});
        wdata_rsv_unused = reg_wdata[6];
    end

    nvm_prot_grow_guard #(
        .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .LOW_BASE(LOW_BASE),
        .OUT_ADDR(ARR_BASE), .GRAN_W(GRAN_W),
        .HI_MIN_W(HI_MIN_W), .LO_MIN_W(LO_MIN_W)
    ) i_guard (
        .cur_cfg     (cfg_q),
        .nxt_cfg     (wr_cfg),
        .grows_only  (grows_only),
        .cur_any_prot(any_prot)
    );

    nvm_prot_cmd_check #(
        .ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR), .LOW_BASE(LOW_BASE),
        .HI_MIN_W(HI_MIN_W), .LO_MIN_W(LO_MIN_W)
    ) i_cmd (
        .cfg     (cfg_q),
        .kind    (cmd_kind_t'(cmd_type)),
        .addr    (cmd_addr),
        .any_prot(any_prot),
        .deny    (cmd_deny)
    );

    // Write acceptance: size fields frozen while enabled, set may only grow
    always_comb begin
        size_ok = (cfg_q.hi_dis || (wr_cfg.hi_size == cfg_q.hi_size)) &&
                  (cfg_q.lo_dis || (wr_cfg.lo_size == cfg_q.lo_size));
        wr_accept = reg_wr && size_ok && grows_only;
    end

    // Configuration register: reset, load, then accepted software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= FAULT_CFG;
            rsv_q <= 1'b1;
        end else if (load_valid) begin
            cfg_q <= load_dbl_fault ? FAULT_CFG : ld_cfg;
            rsv_q <= load_dbl_fault ? 1'b1 : load_byte[6];
        end else if (wr_accept) begin
            cfg_q <= wr_cfg;
        end
    end

    // Registered grant/deny answer and sticky violation flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            prot_viol <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_grant <= cmd_valid && !cmd_deny;
            prot_viol <= (cmd_valid && cmd_deny) || (prot_viol && !stat_clr);
        end
    end

    assign prot_cfg = {cfg_q.mode, rsv_q, cfg_q.hi_dis, cfg_q.hi_size,
                       cfg_q.lo_dis, cfg_q.lo_size};

    AST_FAULT_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n) load_valid && load_dbl_fault |=> prot_cfg == 8'h7F); // R2
    AST_LOAD_OVER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) load_valid && !load_dbl_fault |=> prot_cfg == $past(load_byte)); // R10
    AST_HI_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !load_valid && !prot_cfg[5] |=> prot_cfg[4:3] == $past(prot_cfg[4:3])); // R7
    AST_LO_SIZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !load_valid && !prot_cfg[2] |=> prot_cfg[1:0] == $past(prot_cfg[1:0])); // R7
    AST_RSV_KEPT: assert property (@(posedge clk) disable iff (!rst_n) !load_valid |=> prot_cfg[6] == $past(prot_cfg[6])); // R8
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> rsp_valid); // R4
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !cmd_valid |=> !rsp_valid && !rsp_grant); // R4
    AST_DENY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_grant |-> prot_viol); // R9
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) prot_viol && !stat_clr |=> prot_viol); // R9

endmodule

// File: tb/test_nvm_prot_unit.sv
module test_nvm_prot_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0, load_dbl_fault = 1'b0;
    logic [7:0]  load_byte = 8'h00;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = 2'b00;
    logic [17:0] cmd_addr = 18'h0;
    logic        stat_clr = 1'b0;
    logic [7:0]  prot_cfg;
    logic        rsp_valid, rsp_grant, prot_viol;

    int    checks = 0, fails = 0, cyc = 0;
    bit    started = 0, done = 0;
    string cur_req = "R1";

    // reference model state
    bit [7:0] m_cfg;
    bit       m_rv, m_rg, m_viol;

    always #5 clk = ~clk;

    nvm_prot_unit i_nvm_prot_unit (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid),
        .load_dbl_fault(load_dbl_fault), .load_byte(load_byte),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .cmd_valid(cmd_valid),
        .cmd_type(cmd_type), .cmd_addr(cmd_addr), .stat_clr(stat_clr),
        .prot_cfg(prot_cfg), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .prot_viol(prot_viol)
    );

    // R3: protection of one address computed from window bounds
    function automatic bit mprot(int a, bit [7:0] c);
        int hlen = 2048 << c[4:3];
        int llen = 1024 << c[1:0];
        bit inh  = !c[5] && (a >= 'h40000 - hlen);
        bit inl  = !c[2] && (a >= 'h38000) && (a < 'h38000 + llen);
        return c[7] ? (inh || inl) : !(inh || inl);
    endfunction

    function automatic bit any_prot(bit [7:0] c);
        for (int a = 'h20000; a < 'h40000; a += 512)
            if (mprot(a, c)) return 1;
        return 0;
    endfunction

    // R6/R7 write acceptance
    function automatic bit write_ok(bit [7:0] oldc, bit [7:0] newc);
        if (!oldc[5] && newc[4:3] != oldc[4:3]) return 0;
        if (!oldc[2] && newc[1:0] != oldc[1:0]) return 0;
        for (int a = 'h20000; a < 'h40000; a += 512)
            if (mprot(a, oldc) && !mprot(a, newc)) return 0;
        return 1;
    endfunction

    // model update on every edge
    always @(posedge clk) begin
        bit deny;
        bit [7:0] nc;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_cfg = 8'h7F; m_rv = 0; m_rg = 0; m_viol = 0;
        end else begin
            deny   = cmd_type[1] ? any_prot(m_cfg) : mprot(int'(cmd_addr), m_cfg);
            m_viol = (cmd_valid && deny) || (m_viol && !stat_clr);
            m_rv   = cmd_valid;
            m_rg   = cmd_valid && !deny;
            if (load_valid) begin
                m_cfg = load_dbl_fault ? 8'h7F : load_byte;
            end else if (reg_wr) begin
                nc = {reg_wdata[7], m_cfg[6], reg_wdata[5:0]};
                if (write_ok(m_cfg, nc)) m_cfg = nc;
            end
        end
        if (cyc > 50000 && !done) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp=<50000", cyc);
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk(prot_cfg == m_cfg, "prot_cfg", int'(prot_cfg), int'(m_cfg));
            chk(rsp_valid == m_rv, "rsp_valid", int'(rsp_valid), int'(m_rv));
            chk(rsp_grant == m_rg, "rsp_grant", int'(rsp_grant), int'(m_rg));
            chk(prot_viol == m_viol, "prot_viol", int'(prot_viol), int'(m_viol));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic load(bit [7:0] b, bit flt);
        load_valid = 1; load_byte = b; load_dbl_fault = flt;
        tick();
        load_valid = 0; load_dbl_fault = 0;
    endtask

    task automatic wr(bit [7:0] d);
        reg_wr = 1; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic cmd(bit [1:0] t, int a);
        cmd_valid = 1; cmd_type = t; cmd_addr = 18'(a);
        tick();
        cmd_valid = 0;
    endtask

    task automatic clr();
        stat_clr = 1;
        tick();
        stat_clr = 0;
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1;
        tick();

        cur_req = "R2 R3 R4 R5";            // nothing protected
        load(8'hFF, 0);
        cmd(2'b00, 'h20000); cmd(2'b01, 'h3FFFF); cmd(2'b10, 0);

        cur_req = "R2 R4 R5 R9";            // fault load: all protected
        load(8'hA5, 1);
        cmd(2'b00, 'h30000); cmd(2'b11, 0);
        clr(); tick();

        cur_req = "R3 R6 R4";               // grow: high window 8 KB protected
        load(8'hFF, 0);
        wr(8'hD7);
        cmd(2'b00, 'h3DFFF); cmd(2'b00, 'h3E000); cmd(2'b10, 0); clr();

        cur_req = "R7";                     // size change on enabled window
        wr(8'hDF); wr(8'hCF);
        cmd(2'b00, 'h3C000);

        cur_req = "R3 R6";                  // enable low window 8 KB
        wr(8'hD3);
        cmd(2'b01, 'h39FFF); cmd(2'b01, 'h3A000); clr();
        cur_req = "R6";                     // shrink attempts
        wr(8'hF3); wr(8'h53); wr(8'hD7);

        cur_req = "R3 R4";                  // mode 0: windows open
        load(8'h58, 0);
        cmd(2'b00, 'h3C000); cmd(2'b00, 'h3BFFF); cmd(2'b00, 'h383FF);
        cmd(2'b00, 'h38400); cmd(2'b00, 'h20000); clr();
        cur_req = "R7 R6 R8";
        wr(8'h3A); wr(8'h38); wr(8'hF8); wr(8'h00);

        cur_req = "R9";                     // deny and clear together
        cmd_valid = 1; cmd_type = 2'b00; cmd_addr = 18'h20000; stat_clr = 1;
        tick();
        cmd_valid = 0; stat_clr = 0;
        tick(); clr(); tick();

        cur_req = "R10";
        load_valid = 1; load_byte = 8'hFF; reg_wr = 1; reg_wdata = 8'h00;
        tick();
        load_valid = 0; reg_wr = 0;
        tick();

        cur_req = "R4 R5 R6 R7 R8 R9 R10";
        for (int i = 0; i < 600; i++) begin
            load_valid     = ($urandom % 20) == 0;
            load_dbl_fault = ($urandom % 4) == 0;
            load_byte      = 8'($urandom);
            reg_wr         = ($urandom % 3) == 0;
            reg_wdata      = 8'($urandom);
            cmd_valid      = ($urandom % 2) == 0;
            cmd_type       = 2'($urandom);
            cmd_addr       = 18'('h20000 + ($urandom % 'h20000));
            stat_clr       = ($urandom % 8) == 0;
            tick();
        end
        load_valid = 0; reg_wr = 0; cmd_valid = 0; stat_clr = 0;

        cur_req = "R1";
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule